// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the status a NOR-style flash presents on its data bus while an internal program or erase runs. A one-cycle command-completion strobe starts an operation: an erase over a mask of selected sectors, or a program aimed at one address. From that strobe on, the block drives a ready flag and answers each bus read, one clock later, with either a status byte or the word on an external array-data input. Bit 6 of the status byte shows whether an operation is running. Bit 2 shows whether the address read lies in a sector that is being erased.

A level suspend input freezes a running erase. While the erase is frozen, a program command may run, and the erase stays frozen until that program ends. Commands aimed only at protected sectors do not run. Instead they produce a short guard burst of fixed length, and then reads return array data again. The lengths of a normal operation and of the two guard bursts are parameters counted in clock cycles. The sector of an address is given by its top log2(NUM_SECTORS) bits.

Top module: `flash_status_gen`

## Requirements
- R1: A synchronous reset sets `ready` to 1 and `rd_data` to 0, cancels any operation and any suspend, and clears both toggle bits. The first status read after reset therefore shows bit 6 as 1.
- R2: An accepted erase with at least one unprotected selected sector, or an accepted program to an unprotected sector, holds `ready` low for exactly OP_CYCLES clocks. The count starts with the edge that samples `cmd_done`.
- R3: While an operation runs, each read returns a status byte in which bit 6 is inverted from its previous value. Every bit other than 6 and 2 is 0.
- R4: While an erase is pending, whether running or suspended, a read whose sector is selected and not protected inverts bit 2. A read of any other sector leaves bit 2 unchanged.
- R5: With `susp_in` high during a normal erase, `ready` is 1 and the erase count stays frozen. A read of an erasing sector returns status with bit 6 unchanged. A read of any other sector returns `arr_data`.
- R6: A program accepted during suspend holds `ready` low for OP_CYCLES and toggles bit 6. The erase then stays suspended. When `susp_in` falls, the erase runs for its remaining cycles.
- R7: An erase whose selected sectors are all protected holds `ready` low and toggles bit 6 for ERASE_GUARD_CYCLES. Bit 2 never toggles during it. Reads afterwards return array data.
- R8: A program whose address lies in a protected sector holds `ready` low for PROG_GUARD_CYCLES.
- R9: With no operation pending, every read returns `arr_data`. This includes the first read after an operation completes.
- R10: An erase command is ignored while any operation is pending. A program command is ignored while a program runs or an erase runs unsuspended. An ignored command changes neither the timing nor the erase mask.
- R11: A read is answered from the state before the clock edge that samples it. A read in the same cycle as the start strobe returns array data. A read sampled on the last busy edge returns status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_done | input | 1 | One-cycle strobe marking the final write of a command |
| op_is_erase | input | 1 | 1 = erase command, 0 = program command |
| cmd_addr | input | ADDR_W | Program target address |
| erase_sel | input | NUM_SECTORS | Sectors selected for erase |
| prot_mask | input | NUM_SECTORS | Protected sectors |
| susp_in | input | 1 | Level erase-suspend control |
| rd_stb | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Bus read address |
| arr_data | input | 8 | Array word returned when not in status |
| ready | output | 1 | 1 = ready or suspended, 0 = operation running |
| rd_data | output | 8 | Read result, valid the cycle after `rd_stb` |

## Verification
Two functions can fall in the same clock edge: a bus read, and a change of operation state (a start strobe, or the last counted cycle of an operation). The bench provokes both cases. It places a read in the same cycle as `cmd_done` and expects array data. It places a read exactly on the edge that ends the operation and expects status with both toggle bits inverted, while `ready` rises on that same edge. The read after that must return array data.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  localparam int STAT_W = 8;
  localparam int RUN_BIT = 6;
  localparam int SECT_BIT = 2;

  // Status word: only the two toggle positions are ever set.
  function automatic logic [STAT_W-1:0] status_byte(logic run_tog, logic sect_tog);
    logic [STAT_W-1:0] b;
    b = '0;
    b[RUN_BIT] = run_tog;
    b[SECT_BIT] = sect_tog;
    return b;
  endfunction

  // Cycle count of an operation: guard burst if nothing may be touched.
  function automatic int unsigned run_len(logic blocked, int unsigned normal_len,
                                          int unsigned guard_len);
    return blocked ? guard_len : normal_len;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fsg_sector_decode.sv
module fsg_sector_decode #(
  parameter int ADDR_W = 8,
  parameter int NUM_SECTORS = 8
) (
  input  logic [ADDR_W-1:0]      addr,
  output logic [NUM_SECTORS-1:0] hit
);
  localparam int SEC_W = $clog2(NUM_SECTORS);
  localparam int SHIFT = ADDR_W - SEC_W;

  logic [ADDR_W-1:0] sec_idx;
  assign sec_idx = addr >> SHIFT;

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_hit
    assign hit[s] = (sec_idx == ADDR_W'(s));
  end

  always_comb begin
    assert ($onehot0(hit)) else $error("AST_ONE_SECTOR"); // R4
  end
endmodule

// File: rtl/fsg_op_timer.sv
module fsg_op_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  input  logic             hold,
  output logic             active
);
  logic [CNT_W-1:0] cnt;
  logic             last_tick;

  assign last_tick = active && !hold && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= len;
    end else if (active && !hold) begin
      if (last_tick) active <= 1'b0;
      cnt <= cnt - CNT_W'(1);
    end
  end

  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (rst)
    start |=> (active && cnt == $past(len))) else $error("AST_TMR_LOAD"); // R2
  AST_TMR_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (active && hold && !start) |=> (active && $stable(cnt))) else $error("AST_TMR_FREEZE"); // R5
endmodule

// File: rtl/fsg_read_path.sv
module fsg_read_path
  import flash_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic              run_en,
  input  logic              sect_en,
  input  logic [STAT_W-1:0] arr_data,
  output logic [STAT_W-1:0] rd_data
);
  logic run_tog, sect_tog;
  logic run_nxt, sect_nxt, status_sel;

  assign run_nxt    = run_tog ^ run_en;
  assign sect_nxt   = sect_tog ^ sect_en;
  assign status_sel = run_en || sect_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_tog  <= 1'b0;
      sect_tog <= 1'b0;
      rd_data  <= '0;
    end else if (rd_stb) begin
      run_tog  <= run_nxt;
      sect_tog <= sect_nxt;
      rd_data  <= status_sel ? status_byte(run_nxt, sect_nxt) : arr_data;
    end
  end

  AST_RUN_FLIP: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && run_en) |=> (run_tog != $past(run_tog))) else $error("AST_RUN_FLIP"); // R3
  AST_RUN_STEADY: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !run_en) |=> $stable(run_tog)) else $error("AST_RUN_STEADY"); // R5
  AST_SECT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!rd_stb || !sect_en) |=> $stable(sect_tog)) else $error("AST_SECT_IDLE"); // R4
  AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !status_sel) |=> (rd_data == $past(arr_data))) else $error("AST_ARRAY_PASS"); // R9
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int NUM_SECTORS        = 8,
  parameter int ADDR_W             = 8,
  parameter int OP_CYCLES          = 12,
  parameter int ERASE_GUARD_CYCLES = 30,
  parameter int PROG_GUARD_CYCLES  = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_done,
  input  logic                   op_is_erase,
  input  logic [ADDR_W-1:0]      cmd_addr,
  input  logic [NUM_SECTORS-1:0] erase_sel,
  input  logic [NUM_SECTORS-1:0] prot_mask,
  input  logic                   susp_in,
  input  logic                   rd_stb,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [STAT_W-1:0]      arr_data,
  output logic                   ready,
  output logic [STAT_W-1:0]      rd_data
);
  localparam int MAX_LEN = max3(OP_CYCLES, ERASE_GUARD_CYCLES, PROG_GUARD_CYCLES);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  // Sector decode of the read and command addresses
  logic [NUM_SECTORS-1:0] rd_hit, cmd_hit;

  fsg_sector_decode #(.ADDR_W(ADDR_W), .NUM_SECTORS(NUM_SECTORS)) u_rd_dec (
    .addr(rd_addr), .hit(rd_hit));
  fsg_sector_decode #(.ADDR_W(ADDR_W), .NUM_SECTORS(NUM_SECTORS)) u_cmd_dec (
    .addr(cmd_addr), .hit(cmd_hit));

  // Operation state, named for the checks below
  logic                   er_pend, pg_act, er_guard;
  logic [NUM_SECTORS-1:0] eff_mask, live_mask;
  logic                   er_hold, er_suspended, er_run;
  logic                   acc_erase, acc_prog, all_prot, pg_blocked;
  logic [CNT_W-1:0]       er_len, pg_len;
  logic                   run_en, sect_en;

  assign live_mask    = erase_sel & ~prot_mask;
  assign all_prot     = (live_mask == '0);
  assign pg_blocked   = |(cmd_hit & prot_mask);
  assign er_hold      = (susp_in || pg_act) && !er_guard;
  assign er_suspended = er_pend && er_hold;
  assign er_run       = er_pend && !er_hold;

  assign acc_erase = cmd_done && op_is_erase && !er_pend && !pg_act;
  assign acc_prog  = cmd_done && !op_is_erase && !pg_act && (!er_pend || er_suspended);

  assign er_len = CNT_W'(run_len(all_prot, OP_CYCLES, ERASE_GUARD_CYCLES));
  assign pg_len = CNT_W'(run_len(pg_blocked, OP_CYCLES, PROG_GUARD_CYCLES));

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_mask <= '0;
      er_guard <= 1'b0;
    end else if (acc_erase) begin
      eff_mask <= live_mask;
      er_guard <= all_prot;
    end
  end

  fsg_op_timer #(.CNT_W(CNT_W)) u_er_tmr (
    .clk(clk), .rst(rst), .start(acc_erase), .len(er_len),
    .hold(er_hold), .active(er_pend));

  fsg_op_timer #(.CNT_W(CNT_W)) u_pg_tmr (
    .clk(clk), .rst(rst), .start(acc_prog), .len(pg_len),
    .hold(1'b0), .active(pg_act));

  assign run_en  = er_run || pg_act;
  assign sect_en = er_pend && |(rd_hit & eff_mask);
  assign ready   = !run_en;

  fsg_read_path u_rd (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .run_en(run_en),
    .sect_en(sect_en), .arr_data(arr_data), .rd_data(rd_data));

  AST_ERASE_REJECT: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && op_is_erase && (er_pend || pg_act)) |=> $stable(eff_mask))
    else $error("AST_ERASE_REJECT"); // R10
  AST_SUSP_KEEP: assert property (@(posedge clk) disable iff (rst)
    (er_pend && susp_in && !er_guard) |=> er_pend) else $error("AST_SUSP_KEEP"); // R5
  AST_PROG_BUSY: assert property (@(posedge clk) disable iff (rst)
    acc_prog |=> !ready) else $error("AST_PROG_BUSY"); // R6
  AST_GUARD_NO_SECT: assert property (@(posedge clk) disable iff (rst)
    er_guard |-> !sect_en) else $error("AST_GUARD_NO_SECT"); // R7
  AST_READY_RESET: assert property (@(posedge clk)
    rst |=> ready) else $error("AST_READY_RESET"); // R1
endmodule

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;
  localparam int NS  = 8;
  localparam int AW  = 8;
  localparam int OPC = 12;
  localparam int EPC = 30;
  localparam int PPC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_done = 1'b0, op_is_erase = 1'b0, susp_in = 1'b0, rd_stb = 1'b0;
  logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
  logic [NS-1:0] erase_sel = '0, prot_mask = '0;
  logic [7:0] arr_data = '0;
  logic ready;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  flash_status_gen #(.NUM_SECTORS(NS), .ADDR_W(AW), .OP_CYCLES(OPC),
    .ERASE_GUARD_CYCLES(EPC), .PROG_GUARD_CYCLES(PPC)) u_flash_status_gen (
    .clk(clk), .rst(rst), .cmd_done(cmd_done), .op_is_erase(op_is_erase),
    .cmd_addr(cmd_addr), .erase_sel(erase_sel), .prot_mask(prot_mask),
    .susp_in(susp_in), .rd_stb(rd_stb), .rd_addr(rd_addr), .arr_data(arr_data),
    .ready(ready), .rd_data(rd_data));

  // {is_erase, select, protect, address, expected busy length}
  localparam logic [32:0] VEC [5] = '{
    {1'b1, 8'h0C, 8'h00, 8'h00, 8'(OPC)},
    {1'b1, 8'h03, 8'h03, 8'h00, 8'(EPC)},
    {1'b1, 8'h0F, 8'h03, 8'h00, 8'(OPC)},
    {1'b0, 8'h00, 8'h04, 8'h40, 8'(PPC)},
    {1'b0, 8'h00, 8'h04, 8'hA0, 8'(OPC)}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(logic er, logic [NS-1:0] sel, logic [NS-1:0] prot, logic [AW-1:0] a);
    op_is_erase = er; erase_sel = sel; prot_mask = prot; cmd_addr = a;
    cmd_done = 1'b1;
    tick();
    cmd_done = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [7:0] arr);
    rd_addr = a; arr_data = arr; rd_stb = 1'b1;
    tick();
    rd_stb = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      n++;
      tick();
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) tick();
    chk("R1 ready in reset", int'(ready), 1);
    rst = 1'b0;
    tick();
    chk("R1 ready after reset", int'(ready), 1);
    chk("R1 rd_data after reset", int'(rd_data), 8'h00);
    rd(8'h10, 8'hC3);
    chk("R9 idle read", int'(rd_data), 8'hC3);

    // Table walk: busy length of each command kind (R2, R7, R8)
    for (int i = 0; i < 5; i++) begin
      logic [32:0] v;
      string tag;
      v = VEC[i];
      issue(v[32], v[31:24], v[23:16], v[15:8]);
      busy_len(n);
      if (v[32]) tag = (int'(v[7:0]) == EPC) ? "R7 guard erase length" : "R2 erase length";
      else tag = (int'(v[7:0]) == PPC) ? "R8 guard program length" : "R2 program length";
      chk(tag, n, int'(v[7:0]));
      rd(8'h00, 8'h11 + 8'(i));
      chk("R9 read after completion", int'(rd_data), 8'h11 + i);
    end

    // Toggle rules during a running erase; sector 4 protected, sector 5 erasing
    issue(1'b1, 8'h30, 8'h10, 8'h00);
    rd(8'hA0, 8'hEE);
    chk("R4 erasing sector read", int'(rd_data), 8'h44);
    rd(8'h80, 8'hEE);
    chk("R4 protected sector bit2 steady", int'(rd_data), 8'h04);
    rd(8'h05, 8'hEE);
    chk("R3 other sector bit6 flips", int'(rd_data), 8'h44);
    busy_len(n);
    rd(8'hA0, 8'h5A);
    chk("R9 first read after erase", int'(rd_data), 8'h5A);

    // Suspend and program during suspend; toggles now bit6=1 bit2=1
    issue(1'b1, 8'h02, 8'h00, 8'h00);
    tick();
    tick();
    susp_in = 1'b1;
    tick();
    chk("R5 ready in suspend", int'(ready), 1);
    rd(8'h20, 8'hEE);
    chk("R5 suspended sector read", int'(rd_data), 8'h40);
    rd(8'h60, 8'h33);
    chk("R5 unselected read gives array", int'(rd_data), 8'h33);
    repeat (20) tick();
    chk("R5 erase frozen", int'(ready), 1);
    rd(8'h3F, 8'hEE);
    chk("R5 still pending", int'(rd_data), 8'h44);
    issue(1'b0, 8'h00, 8'h00, 8'h60);
    chk("R6 program busy", int'(ready), 0);
    rd(8'h60, 8'hEE);
    chk("R6 program toggles bit6", int'(rd_data), 8'h04);
    busy_len(n);
    chk("R6 program length", n, OPC - 1);
    rd(8'h20, 8'hFF);
    chk("R6 back in suspend", int'(rd_data), 8'h00);
    issue(1'b1, 8'h01, 8'h00, 8'h00);
    chk("R10 erase ignored ready", int'(ready), 1);
    rd(8'h00, 8'h77);
    chk("R10 mask unchanged", int'(rd_data), 8'h77);
    susp_in = 1'b0;
    n = 0;
    do begin
      tick();
      n++;
    end while (!ready && n < 1000);
    chk("R6 erase resumes remaining", n, 10);
    rd(8'h20, 8'h12);
    chk("R9 after resumed erase", int'(rd_data), 8'h12);

    // Same-cycle read and start, then read on the last busy edge
    op_is_erase = 1'b1; erase_sel = 8'h01; prot_mask = 8'h00;
    cmd_done = 1'b1; rd_stb = 1'b1; rd_addr = 8'h00; arr_data = 8'h99;
    tick();
    cmd_done = 1'b0; rd_stb = 1'b0;
    chk("R11 read with start", int'(rd_data), 8'h99);
    chk("R2 busy after start", int'(ready), 0);
    repeat (OPC - 1) tick();
    chk("R2 busy before last edge", int'(ready), 0);
    rd(8'h00, 8'hEE);
    chk("R11 read on last edge", int'(rd_data), 8'h44);
    chk("R2 ready on last edge", int'(ready), 1);
    rd(8'h00, 8'h21);
    chk("R9 read after last edge", int'(rd_data), 8'h21);

    // Reset in mid-operation
    issue(1'b1, 8'h01, 8'h00, 8'h00);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 reset cancels", int'(ready), 1);
    chk("R1 reset clears data", int'(rd_data), 8'h00);
    rd(8'h00, 8'h6C);
    chk("R1 no erase after reset", int'(rd_data), 8'h6C);
    issue(1'b1, 8'h01, 8'h00, 8'h00);
    rd(8'h00, 8'hEE);
    chk("R1 toggles cleared", int'(rd_data), 8'h44);
    busy_len(n);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule